// File: doc/BRIEF.md
# Double-Buffered Clock Register File

This block is the software-facing register file of a real-time clock that sits in the eight highest locations of a 2K x 8 byte-addressed space. It keeps its own visible copy of the seven time bytes (seconds through year) apart from the live time counters held by a separate counter block. The visible copy follows the counters on every counter tick. A control byte can freeze it, so that a consistent snapshot can be read, or open it for staging, so that a new time can be written and then handed to the counters in one step. The counters are never stopped by either mode.

Access uses a synchronous byte port with chip select, write enable, an 11-bit address and 8-bit write and read data. The counter side gets a one-cycle load strobe with the staged time, and two stored control bits: oscillator stop and frequency test. A power-fail input blocks every access while it is high. Bits of the clock bytes that carry no time value act as plain storage and are never changed by a refresh.

Top module: `rtc_regfile`

## Requirements
- R1: Only addresses 0x7F8..0x7FF reach the registers (index = address bits 2:0; 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5date, 6 month, 7 year). Reads of any other address return 0x00 and writes to them change nothing.
- R2: A read (cs_i=1, we_i=0) returns the addressed byte on rdata_o in the cycle after the request. rdata_o is 0x00 in every cycle that follows a cycle without a valid read.
- R3: While control bits 7 and 6 are both 0, each cycle with cnt_tick_i=1 copies the counter byte into the time bits of each visible byte. cnt_time_i holds seconds in bits 7:0 up to year in bits 55:48.
- R4: While control bit 6 (read hold) is 1 and bit 7 is 0, the visible bytes keep the values captured when bit 6 was set. A write that clears the hold refreshes all seven bytes from cnt_time_i at once.
- R5: While control bit 7 (write hold) is 1, ticks do not reach the visible bytes and written values stay. A write that clears bit 7 raises load_o for exactly one cycle, the cycle after that write, with load_time_o holding the seven staged bytes in the cnt_time_i layout.
- R6: Bit 7 takes priority over bit 6. Clearing bit 6 while bit 7 stays 1 gives no refresh and no load. Clearing bit 7 while bit 6 stays 1 loads the counters, and the visible bytes remain frozen.
- R7: Time bits per byte are seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF. The other bits, including control bits 5:0, read back as last written and are never changed by a refresh.
- R8: osc_stop_o follows seconds bit 7 and ftest_o follows day bit 6, as written.
- R9: When day bit 6 is 1 and seconds bit 7 is 0, bit 0 of a seconds read returns ftest_clk_i as sampled in the read cycle.
- R10: While pwr_fail_i is 1, no read or write takes place: writes are dropped and rdata_o is 0x00 in the next cycle.
- R11: After reset every register, rdata_o, load_o, load_time_o, osc_stop_o and ftest_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pwr_fail_i | input | 1 | Supply out of tolerance, blocks all access |
| cs_i | input | 1 | Chip select |
| we_i | input | 1 | Write enable (1 write, 0 read) |
| addr_i | input | ADDR_W (11) | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the request |
| cnt_tick_i | input | 1 | Counters advanced this cycle |
| cnt_time_i | input | 56 | Live counter bytes, seconds lowest |
| load_o | output | 1 | One-cycle strobe that loads the counters |
| load_time_o | output | 56 | Staged time for the counters |
| osc_stop_o | output | 1 | Oscillator stop bit |
| ftest_o | output | 1 | Frequency test bit |
| ftest_clk_i | input | 1 | Test square wave for seconds bit 0 |

## Verification
The assertions assume the counter block reacts to the load strobe and does not drive a tick in the same cycle. They also assume that power-fail, chip select and write enable are clean synchronous levels with no X. The bench drives all inputs on the falling edge. It suppresses ticks in the cycle of a load and while the oscillator-stop bit is set. Random traffic writes the control byte only with values that keep this contract.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BYTE_W  = 8;
    localparam int NREG    = 8;
    localparam int IDX_W   = $clog2(NREG);
    localparam int TIME_W  = BYTE_W * (NREG - 1);

    localparam int HOLD_WR_BIT = 7;
    localparam int HOLD_RD_BIT = 6;
    localparam int OSC_STOP_BIT = 7;
    localparam int FTEST_BIT   = 6;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NREG-1:0][BYTE_W-1:0] bank_t;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTRL = 3'd0,
        IDX_SEC  = 3'd1,
        IDX_MIN  = 3'd2,
        IDX_HOUR = 3'd3,
        IDX_DAY  = 3'd4,
        IDX_DATE = 3'd5,
        IDX_MON  = 3'd6,
        IDX_YEAR = 3'd7
    } reg_idx_e;

    // Bits of each byte that carry a count value; the rest is plain storage.
    function automatic byte_t time_mask(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_SEC:  time_mask = 8'h7F;
            IDX_MIN:  time_mask = 8'h7F;
            IDX_HOUR: time_mask = 8'h3F;
            IDX_DAY:  time_mask = 8'h07;
            IDX_DATE: time_mask = 8'h3F;
            IDX_MON:  time_mask = 8'h1F;
            IDX_YEAR: time_mask = 8'hFF;
            default:  time_mask = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              pwr_fail_i,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              wr_en_o,
    output logic              rd_en_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic hit;
    logic ce;

    assign hit     = &addr_i[ADDR_W-1:IDX_W];
    assign ce      = cs_i & ~pwr_fail_i;
    assign wr_en_o = ce & hit & we_i;
    assign rd_en_o = ce & hit & ~we_i;
    assign idx_o   = addr_i[IDX_W-1:0];
endmodule

// File: rtl/rtc_readmux.sv
module rtc_readmux
    import rtc_pkg::*;
(
    input  bank_t             regs_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              ftest_clk_i,
    output byte_t             data_o
);
    logic ft_active;

    assign ft_active = regs_i[IDX_DAY][FTEST_BIT] & ~regs_i[IDX_SEC][OSC_STOP_BIT];

    always_comb begin
        data_o = regs_i[idx_i];
        if ((idx_i == IDX_SEC) && ft_active) begin
            data_o[0] = ftest_clk_i;
        end
    end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pwr_fail_i,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic              cnt_tick_i,
    input  logic [55:0]       cnt_time_i,
    output logic              load_o,
    output logic [55:0]       load_time_o,
    output logic              osc_stop_o,
    output logic              ftest_o,
    input  logic              ftest_clk_i
);
    typedef struct packed {
        bank_t               regs;
        byte_t               rdata;
        logic                load;
        logic [TIME_W-1:0]   ltime;
    } state_t;

    state_t s_d, s_q;

    logic             wr_en, rd_en;
    logic [IDX_W-1:0] idx;
    byte_t            rd_byte;
    logic             frozen_q, frozen_d, wr_hold_fall;

    rtc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .pwr_fail_i (pwr_fail_i),
        .cs_i       (cs_i),
        .we_i       (we_i),
        .addr_i     (addr_i),
        .wr_en_o    (wr_en),
        .rd_en_o    (rd_en),
        .idx_o      (idx)
    );

    rtc_readmux u_mux (
        .regs_i      (s_q.regs),
        .idx_i       (idx),
        .ftest_clk_i (ftest_clk_i),
        .data_o      (rd_byte)
    );

    assign frozen_q = s_q.regs[IDX_CTRL][HOLD_WR_BIT] | s_q.regs[IDX_CTRL][HOLD_RD_BIT];

    always_comb begin
        s_d      = s_q;
        s_d.load = 1'b0;
        // Follow the counters while nothing holds the visible copy.
        if (!frozen_q && cnt_tick_i) begin
            for (int i = 1; i < NREG; i++) begin
                s_d.regs[i] = (s_q.regs[i] & ~time_mask(i[IDX_W-1:0]))
                            | (cnt_time_i[BYTE_W*(i-1) +: BYTE_W] & time_mask(i[IDX_W-1:0]));
            end
        end
        if (wr_en) begin
            s_d.regs[idx] = wdata_i;
        end
        frozen_d     = s_d.regs[IDX_CTRL][HOLD_WR_BIT] | s_d.regs[IDX_CTRL][HOLD_RD_BIT];
        wr_hold_fall = s_q.regs[IDX_CTRL][HOLD_WR_BIT] & ~s_d.regs[IDX_CTRL][HOLD_WR_BIT];
        if (wr_hold_fall) begin
            s_d.load = 1'b1;
            for (int i = 1; i < NREG; i++) begin
                s_d.ltime[BYTE_W*(i-1) +: BYTE_W] = s_d.regs[i];
            end
        end else if (frozen_q && !frozen_d) begin
            for (int i = 1; i < NREG; i++) begin
                s_d.regs[i] = (s_d.regs[i] & ~time_mask(i[IDX_W-1:0]))
                            | (cnt_time_i[BYTE_W*(i-1) +: BYTE_W] & time_mask(i[IDX_W-1:0]));
            end
        end
        s_d.rdata = rd_en ? rd_byte : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o     = s_q.rdata;
    assign load_o      = s_q.load;
    assign load_time_o = s_q.ltime;
    assign osc_stop_o  = s_q.regs[IDX_SEC][OSC_STOP_BIT];
    assign ftest_o     = s_q.regs[IDX_DAY][FTEST_BIT];

    // R5
    load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |=> !load_o);

    // R5
    load_after_wclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(load_o) |-> ($past(s_q.regs[IDX_CTRL][HOLD_WR_BIT]) && !s_q.regs[IDX_CTRL][HOLD_WR_BIT]));

    // R10
    pf_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_fail_i |=> (rdata_o == 8'h00));

    // R4
    frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_fail_i && frozen_q) |=> $stable(s_q.regs));

    // R8
    osc_bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en |=> $stable(osc_stop_o) && $stable(ftest_o));
endmodule

// File: tb/sim_rtc_regfile.sv
module sim_rtc_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pf = 1'b0, cs = 1'b0, we = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        tick = 1'b0;
    logic [55:0] cnt_time;
    logic        load;
    logic [55:0] load_time;
    logic        osc_stop, ftest;
    logic        fclk = 1'b0;

    int checks = 0, fails = 0;
    bit done = 0;
    bit tick_en = 0, fclk_auto = 1;
    int cyc_n = 0;
    logic [7:0] live [1:7];
    logic [7:0] m_reg [0:7];
    logic [7:0] m_rd;
    logic       m_load;
    logic [55:0] m_lt;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 1; i < 8; i++) cnt_time[8*(i-1) +: 8] = live[i];
    end

    rtc_regfile u0 (
        .clk_i(clk), .rst_ni(rst_n), .pwr_fail_i(pf), .cs_i(cs), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cnt_tick_i(tick),
        .cnt_time_i(cnt_time), .load_o(load), .load_time_o(load_time),
        .osc_stop_o(osc_stop), .ftest_o(ftest), .ftest_clk_i(fclk)
    );

    function automatic logic [7:0] mk(input int i);
        case (i)
            1: return 8'h7F; 2: return 8'h7F; 3: return 8'h3F; 4: return 8'h07;
            5: return 8'h3F; 6: return 8'h1F; 7: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference step: apply the requirements to the inputs of this cycle.
    task automatic model_step();
        logic [7:0] n [0:7];
        bit valid_cs, wr, rd, frz, frz_n, wfall;
        int ix;
        logic [7:0] v;
        valid_cs = cs && !pf && (addr[10:3] == 8'hFF);
        wr = valid_cs && we;
        rd = valid_cs && !we;
        ix = int'(addr[2:0]);
        for (int i = 0; i < 8; i++) n[i] = m_reg[i];
        frz = (m_reg[0][7] || m_reg[0][6]);
        if (!frz && tick)
            for (int i = 1; i < 8; i++) n[i] = (n[i] & ~mk(i)) | (live[i] & mk(i));
        if (wr) n[ix] = wdata;
        frz_n = (n[0][7] || n[0][6]);
        wfall = m_reg[0][7] && !n[0][7];
        m_load = 1'b0;
        if (wfall) begin
            m_load = 1'b1;
            for (int i = 1; i < 8; i++) m_lt[8*(i-1) +: 8] = n[i];
        end else if (frz && !frz_n) begin
            for (int i = 1; i < 8; i++) n[i] = (n[i] & ~mk(i)) | (live[i] & mk(i));
        end
        v = m_reg[ix];
        if (ix == 1 && m_reg[4][6] && !m_reg[1][7]) v[0] = fclk;
        m_rd = rd ? v : 8'h00;
        for (int i = 0; i < 8; i++) m_reg[i] = n[i];
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R2 rdata", 64'(rdata), 64'(m_rd));
        chk("R5 load_o", 64'(load), 64'(m_load));
        if (m_load) chk("R5 load_time", 64'(load_time), 64'(m_lt));
        chk("R8 osc_stop", 64'(osc_stop), 64'(m_reg[1][7]));
        chk("R8 ftest", 64'(ftest), 64'(m_reg[4][6]));
        cyc_n++;
        if (load) begin
            for (int i = 1; i < 8; i++) live[i] = load_time[8*(i-1) +: 8];
            tick = 1'b0;
        end else begin
            tick = tick_en && (cyc_n % 3 == 0) && !m_reg[1][7];
            if (tick) for (int i = 1; i < 8; i++) live[i] = live[i] + 8'(i);
        end
        if (fclk_auto && (cyc_n % 4 == 0)) fclk = ~fclk;
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        cs = 1; we = 1; addr = a; wdata = d;
        cyc();
        cs = 0; we = 0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        cs = 1; we = 0; addr = a;
        cyc();
        d = rdata;
        cs = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, cap;
        for (int i = 1; i < 8; i++) live[i] = 8'(i * 17);
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_rd = 0; m_load = 0; m_lt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        chk("R11 rdata", 64'(rdata), 0);
        chk("R11 load", 64'(load), 0);
        chk("R11 load_time", 64'(load_time), 0);
        chk("R11 osc", 64'(osc_stop), 0);
        chk("R11 ftest", 64'(ftest), 0);
        rd(11'h7F8, v); chk("R11 ctrl", 64'(v), 0);

        // R3 following the counters
        tick_en = 1; idle(20); tick_en = 0; idle(2);
        rd(11'h7F9, v); chk("R3 seconds", 64'(v), 64'(live[1] & 8'h7F));
        rd(11'h7FF, v); chk("R3 year", 64'(v), 64'(live[7]));

        // R7 spare bits survive refresh
        wr(11'h7FA, 8'hC5);
        tick_en = 1; idle(10); tick_en = 0; idle(2);
        rd(11'h7FA, v); chk("R7 minutes spare", 64'(v), 64'(8'h80 | (live[2] & 8'h7F)));
        wr(11'h7F8, 8'h15);
        rd(11'h7F8, v); chk("R7 ctrl spare", 64'(v), 64'h15);

        // R4 read hold
        wr(11'h7F8, 8'h40);
        cap = live[1] & 8'h7F;
        tick_en = 1; idle(15);
        rd(11'h7F9, v); chk("R4 frozen seconds", 64'(v), 64'(cap));
        tick_en = 0; idle(1);
        wr(11'h7F8, 8'h00);
        rd(11'h7F9, v); chk("R4 release refresh", 64'(v), 64'(live[1] & 8'h7F));

        // R5 write hold and load
        wr(11'h7F8, 8'h80);
        wr(11'h7F9, 8'h25); wr(11'h7FA, 8'h59); wr(11'h7FB, 8'h13); wr(11'h7FC, 8'h02);
        wr(11'h7FD, 8'h28); wr(11'h7FE, 8'h02); wr(11'h7FF, 8'h24);
        tick_en = 1; idle(10); tick_en = 0; idle(1);
        rd(11'h7F9, v); chk("R5 staged seconds", 64'(v), 64'h25);
        rd(11'h7FF, v); chk("R5 staged year", 64'(v), 64'h24);
        wr(11'h7F8, 8'h00);
        chk("R5 load strobe", 64'(load), 1);
        chk("R5 load value", 64'(load_time), 64'h24_02_28_02_13_59_25);
        idle(1);
        chk("R5 strobe single", 64'(load), 0);
        rd(11'h7F9, v); chk("R5 after load", 64'(v), 64'h25);

        // R6 priority of the write hold
        wr(11'h7F8, 8'hC0);
        wr(11'h7FB, 8'h07);
        wr(11'h7F8, 8'h80);
        chk("R6 no load on read clear", 64'(load), 0);
        tick_en = 1; idle(8); tick_en = 0; idle(1);
        rd(11'h7FB, v); chk("R6 still staged", 64'(v), 64'h07);
        wr(11'h7F8, 8'hC0);
        wr(11'h7F8, 8'h40);
        chk("R6 load with read hold", 64'(load), 1);
        chk("R6 load hour", 64'(load_time[23:16]), 64'h07);
        tick_en = 1; idle(8); tick_en = 0; idle(1);
        rd(11'h7FB, v); chk("R6 frozen after load", 64'(v), 64'h07);
        wr(11'h7F8, 8'h00);

        // R8 control bits
        wr(11'h7F9, 8'h80); chk("R8 osc stop set", 64'(osc_stop), 1);
        wr(11'h7FC, 8'h40); chk("R8 ftest set", 64'(ftest), 1);
        wr(11'h7F9, 8'h00); chk("R8 osc stop clear", 64'(osc_stop), 0);

        // R9 test clock on seconds bit 0
        fclk_auto = 0; fclk = 1;
        rd(11'h7F9, v); chk("R9 test bit high", 64'(v), 64'h01);
        fclk = 0;
        rd(11'h7F9, v); chk("R9 test bit low", 64'(v), 64'h00);
        wr(11'h7FC, 8'h00); fclk_auto = 1;

        // R10 power fail
        pf = 1;
        wr(11'h7F9, 8'h33);
        rd(11'h7F9, v); chk("R10 blocked read", 64'(v), 0);
        pf = 0;
        rd(11'h7F9, v); chk("R10 write dropped", 64'(v), 64'h00);

        // R1 decode
        wr(11'h012, 8'h5A);
        rd(11'h012, v); chk("R1 outside read", 64'(v), 0);
        wr(11'h7F7, 8'h5A);
        rd(11'h7F7, v); chk("R1 below window", 64'(v), 0);

        // Mixed traffic against the reference model
        tick_en = 1;
        for (int k = 0; k < 600; k++) begin
            int r;
            r = $urandom_range(0, 9);
            pf = ($urandom_range(0, 15) == 0);
            if (r < 3) begin
                logic [7:0] d;
                d = 8'($urandom);
                if (r == 0) begin
                    logic [1:0] h;
                    h = 2'($urandom_range(0, 3));
                    d = {h, d[5:0]};
                    wr(11'h7F8, d);
                end else begin
                    wr({8'hFF, 3'($urandom_range(1, 7))}, d);
                end
            end else if (r < 7) begin
                rd({8'hFF, 3'($urandom_range(0, 7))}, v);
            end else if (r == 7) begin
                rd(11'($urandom), v);
            end else begin
                idle(1);
            end
        end
        pf = 0;
        idle(4);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule